// File: doc/BRIEF.md
# Multi-Lane Byte Striper

This block sits between a byte-wide packet stream and a bank of per-lane symbol encoders in a serial link. On the transmit side it takes one byte per cycle on a valid/ready stream and collects consecutive bytes into a lane group. The first byte of a group goes to lane 0, the next to lane 1, and so on up to the last active lane. When the group is full, or the packet ends, the whole group is issued in a single cycle with one byte per active lane. When a packet ends part-way through a group, the lanes left over in that group carry a pad byte flagged as not real.

On the receive side it takes one group per strobe, discards padded and inactive lanes, and returns the surviving bytes one per cycle in their original order, with the packet-end marker intact. A transmit half wired back to a receive half of the same width therefore gives back exactly the byte stream it was fed.

The number of active lanes is loaded once, when link bring-up has settled, through a configure strobe. Widths of 1, 2, 4, 8, 12, 16 and 32 lanes are accepted. The non-power-of-two 12-lane case uses the same round-robin as the others.

Top module: `lane_byte_striper`

## Requirements
- R1: `cfg_width` is the lane count as a plain binary number and is sampled only in a cycle where `cfg_load` is high. A value in {1, 2, 4, 8, 12, 16, 32} (and no larger than `MAX_LANES`) appears on `link_width` from the next cycle on, and `link_width` does not change while `cfg_load` is low.
- R2: A sampled value outside that set makes `link_width` 1 and raises `cfg_err` from the next cycle. A later legal load clears `cfg_err`.
- R3: While `cfg_load` is high, `s_ready` is low and a byte offered on the stream is dropped. The load also abandons any group being collected, so that byte never appears on a lane or at `m_data`.
- R4: Bytes accepted at `s_valid && s_ready` fill lanes 0, 1, 2 and so on in acceptance order. In the cycle after the byte that fills lane W-1 (W = `link_width`) or carries `s_last` is accepted, `tx_strobe` is high for one cycle, and each filled lane shows its byte with `tx_lane_act` and `tx_lane_keep` both set.
- R5: In a group cut short by `s_last`, every active lane beyond the last filled one shows `PAD_BYTE` with `tx_lane_act` high and `tx_lane_keep` low. `tx_end` is high exactly with the group that holds the final byte of a packet.
- R6: Lanes with index W or above keep `tx_lane_act` and `tx_lane_keep` low in every cycle, and `tx_lane_act` is all zero in cycles without `tx_strobe`.
- R7: The receive half ignores every lane whose `rx_lane_keep` is low or whose index is W or above. In the cycles after an `rx_strobe`, it outputs that group's kept bytes on `m_data`, one per cycle with `m_valid`, in ascending lane order and after all bytes of earlier groups. `m_last` marks the final kept byte of a group received with `rx_end`.
- R8: With the transmit lanes fed straight into the receive lanes at the same width, the bytes and packet-end markers on `m_*` equal those accepted on `s_*`, in the same order, none lost or added. This holds for every legal width and every packet length when input averages at most one byte per cycle.
- R9: After reset, `link_width` is 1, `cfg_err` is 0, `tx_strobe`, `tx_lane_act` and `tx_lane_keep` are all zero, and `m_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_load | input | 1 | Configure strobe; samples `cfg_width` and restarts both halves |
| cfg_width | input | LW | Requested lane count, binary |
| link_width | output | LW | Lane count in force |
| cfg_err | output | 1 | Last sampled width was not a supported value |
| s_valid | input | 1 | Input byte valid |
| s_data | input | 8 | Input byte |
| s_last | input | 1 | Input byte ends a packet |
| s_ready | output | 1 | Input byte accepted this cycle |
| tx_lane_data | output | 8*MAX_LANES | Per-lane byte toward the encoders, lane i at bits 8i+7:8i |
| tx_lane_act | output | MAX_LANES | Lane carries a symbol this cycle |
| tx_lane_keep | output | MAX_LANES | Lane byte is stream data rather than pad |
| tx_strobe | output | 1 | A lane group is issued this cycle |
| tx_end | output | 1 | Issued group holds the end of a packet |
| rx_strobe | input | 1 | A received lane group is present |
| rx_lane_data | input | 8*MAX_LANES | Received per-lane bytes, same layout as transmit |
| rx_lane_keep | input | MAX_LANES | Received lane byte is real |
| rx_end | input | 1 | Received group holds the end of a packet |
| m_valid | output | 1 | Rebuilt byte valid |
| m_data | output | 8 | Rebuilt byte |
| m_last | output | 1 | Rebuilt byte ends a packet |

## Verification
The bench sweeps every legal width, and a run of illegal codes, over packet lengths from one byte to just past two full groups, with idle gaps in the input. Each length lands on exact fills, one byte over a fill and one byte short of a fill. Short final groups catch a design that pads the wrong lanes, marks pad as real, or forgets `tx_end`, and the receive side would then add bytes to the stream or lose the packet boundary. The 12-lane runs catch a wrap done with a power-of-two mask: lane 12 would be used or lane 0 reached late. A byte pushed during the configure strobe shows up as an extra output byte if it is accepted, and an illegal code left in force instead of falling back to one lane shows up as groups of the wrong size.

// File: rtl/lane_stripe_pkg.sv
package lane_stripe_pkg;

  // True when w is a lane count the link may run at and the instance has that many lanes.
  function automatic logic width_ok(input int unsigned w, input int unsigned max_lanes);
    logic in_set;
    case (w)
      1, 2, 4, 8, 12, 16, 32: in_set = 1'b1;
      default:                in_set = 1'b0;
    endcase
    return in_set && (w <= max_lanes);
  endfunction

  // A group closes on the byte that fills the last active lane, or on a packet end.
  function automatic logic group_closes(input int unsigned fill_idx, input int unsigned width,
                                        input logic last);
    return last || (fill_idx + 1 == width);
  endfunction

endpackage

// File: rtl/lane_stripe_cfg.sv
module lane_stripe_cfg
  import lane_stripe_pkg::*;
#(
  parameter int MAX_LANES = 32,
  parameter int LW        = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_load,
  input  logic [LW-1:0] cfg_width,
  output logic [LW-1:0] width_q,
  output logic          err_q
);

  logic req_ok;
  assign req_ok = width_ok(32'(cfg_width), MAX_LANES);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      width_q <= LW'(1);
      err_q   <= 1'b0;
    end else if (cfg_load) begin
      width_q <= req_ok ? cfg_width : LW'(1);
      err_q   <= !req_ok;
    end
  end

  // R2
  bad_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_load && !req_ok) |=> (err_q && width_q == LW'(1)));

  // R1
  width_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_load |=> $stable(width_q));

endmodule

// File: rtl/lane_stripe_tx.sv
module lane_stripe_tx
  import lane_stripe_pkg::*;
#(
  parameter int         MAX_LANES = 32,
  parameter int         LW        = 6,
  parameter logic [7:0] PAD_BYTE  = 8'h00
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LW-1:0]          width,
  input  logic                   restart,
  input  logic                   s_valid,
  input  logic [7:0]             s_data,
  input  logic                   s_last,
  output logic                   s_ready,
  output logic [MAX_LANES*8-1:0] lane_data,
  output logic [MAX_LANES-1:0]   lane_act,
  output logic [MAX_LANES-1:0]   lane_keep,
  output logic                   grp_strobe,
  output logic                   grp_end
);

  localparam int IW = $clog2(MAX_LANES);

  logic [LW-1:0]                fill_idx;
  logic [MAX_LANES-1:0][7:0]    hold;
  logic [MAX_LANES-1:0][7:0]    data_q;
  logic [MAX_LANES-1:0]         act_mask;
  logic                         take;
  logic                         closing;

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_mask
    assign act_mask[g] = (LW'(g) < width);
  end

  assign s_ready   = !restart;
  assign take      = s_valid && s_ready;
  assign closing   = take && group_closes(32'(fill_idx), 32'(width), s_last);
  assign lane_data = data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill_idx   <= '0;
      hold       <= '0;
      data_q     <= '0;
      lane_act   <= '0;
      lane_keep  <= '0;
      grp_strobe <= 1'b0;
      grp_end    <= 1'b0;
    end else begin
      lane_act   <= '0;
      lane_keep  <= '0;
      grp_strobe <= 1'b0;
      grp_end    <= 1'b0;
      if (restart) begin
        fill_idx <= '0;
      end else if (closing) begin
        for (int i = 0; i < MAX_LANES; i++) begin
          if (i < int'(fill_idx))       data_q[i] <= hold[i];
          else if (i == int'(fill_idx)) data_q[i] <= s_data;
          else if (act_mask[i])         data_q[i] <= PAD_BYTE;
          else                          data_q[i] <= 8'h00;
          lane_keep[i] <= (i <= int'(fill_idx));
        end
        lane_act   <= act_mask;
        grp_strobe <= 1'b1;
        grp_end    <= s_last;
        fill_idx   <= '0;
      end else if (take) begin
        hold[fill_idx[IW-1:0]] <= s_data;
        fill_idx               <= fill_idx + 1'b1;
      end
    end
  end

  // R5
  keep_in_act_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grp_strobe |-> (lane_keep[0] && ((lane_keep & ~lane_act) == '0)));

  // R6
  idle_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lane_act & ~act_mask) == '0) && (grp_strobe || lane_act == '0));

endmodule

// File: rtl/lane_stripe_rx.sv
module lane_stripe_rx #(
  parameter int MAX_LANES = 32,
  parameter int LW        = 6
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [LW-1:0]          width,
  input  logic                   restart,
  input  logic                   rx_strobe,
  input  logic [MAX_LANES*8-1:0] rx_lane_data,
  input  logic [MAX_LANES-1:0]   rx_lane_keep,
  input  logic                   rx_end,
  output logic                   m_valid,
  output logic [7:0]             m_data,
  output logic                   m_last
);

  localparam int IW    = $clog2(MAX_LANES);
  localparam int AW    = IW + 1;
  localparam int DEPTH = 2 ** AW;

  logic [MAX_LANES-1:0][7:0] lane_in;
  logic [MAX_LANES-1:0][7:0] packed_bytes;
  logic [MAX_LANES-1:0]      act_mask;
  logic [IW:0]               wcnt;
  logic [AW-1:0]             wr_ptr, rd_ptr;
  logic [AW:0]               occ;
  logic                      pop;
  logic [8:0]                mem [DEPTH];

  assign lane_in = rx_lane_data;

  for (genvar g = 0; g < MAX_LANES; g++) begin : g_mask
    assign act_mask[g] = (LW'(g) < width);
  end

  // Squeeze kept lanes down to a dense, lane-ordered list.
  always_comb begin
    wcnt         = '0;
    packed_bytes = '0;
    for (int i = 0; i < MAX_LANES; i++) begin
      if (rx_strobe && rx_lane_keep[i] && act_mask[i]) begin
        packed_bytes[wcnt[IW-1:0]] = lane_in[i];
        wcnt                       = wcnt + 1'b1;
      end
    end
  end

  assign pop     = (occ != '0);
  assign m_valid = pop;
  assign {m_last, m_data} = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      occ    <= '0;
    end else begin
      wr_ptr <= wr_ptr + AW'(wcnt);
      rd_ptr <= rd_ptr + AW'(pop);
      occ    <= occ + (AW+1)'(wcnt) - (AW+1)'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int j = 0; j < MAX_LANES; j++) begin
      if (!restart && j < int'(wcnt))
        mem[wr_ptr + AW'(j)] <= {rx_end && (j == int'(wcnt) - 1), packed_bytes[j]};
    end
  end

  // R8
  rx_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_strobe |-> (int'(occ) + int'(wcnt) <= DEPTH));

endmodule

// File: rtl/lane_byte_striper.sv
module lane_byte_striper #(
  parameter int         MAX_LANES = 32,
  parameter logic [7:0] PAD_BYTE  = 8'h00,
  localparam int        LW        = $clog2(MAX_LANES) + 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_load,
  input  logic [LW-1:0]          cfg_width,
  output logic [LW-1:0]          link_width,
  output logic                   cfg_err,
  input  logic                   s_valid,
  input  logic [7:0]             s_data,
  input  logic                   s_last,
  output logic                   s_ready,
  output logic [MAX_LANES*8-1:0] tx_lane_data,
  output logic [MAX_LANES-1:0]   tx_lane_act,
  output logic [MAX_LANES-1:0]   tx_lane_keep,
  output logic                   tx_strobe,
  output logic                   tx_end,
  input  logic                   rx_strobe,
  input  logic [MAX_LANES*8-1:0] rx_lane_data,
  input  logic [MAX_LANES-1:0]   rx_lane_keep,
  input  logic                   rx_end,
  output logic                   m_valid,
  output logic [7:0]             m_data,
  output logic                   m_last
);

  lane_stripe_cfg #(.MAX_LANES(MAX_LANES), .LW(LW)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_width(cfg_width),
    .width_q(link_width), .err_q(cfg_err)
  );

  lane_stripe_tx #(.MAX_LANES(MAX_LANES), .LW(LW), .PAD_BYTE(PAD_BYTE)) u_tx (
    .clk(clk), .rst_n(rst_n), .width(link_width), .restart(cfg_load),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .lane_data(tx_lane_data), .lane_act(tx_lane_act), .lane_keep(tx_lane_keep),
    .grp_strobe(tx_strobe), .grp_end(tx_end)
  );

  lane_stripe_rx #(.MAX_LANES(MAX_LANES), .LW(LW)) u_rx (
    .clk(clk), .rst_n(rst_n), .width(link_width), .restart(cfg_load),
    .rx_strobe(rx_strobe), .rx_lane_data(rx_lane_data), .rx_lane_keep(rx_lane_keep),
    .rx_end(rx_end), .m_valid(m_valid), .m_data(m_data), .m_last(m_last)
  );

endmodule

// File: tb/lane_byte_striper_bench.sv
module lane_byte_striper_bench;

  localparam int         N   = 32;
  localparam int         LW  = 6;
  localparam logic [7:0] PAD = 8'hB6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            cfg_load = 1'b0;
  logic [LW-1:0]   cfg_width = '0;
  logic [LW-1:0]   link_width;
  logic            cfg_err;
  logic            s_valid = 1'b0;
  logic [7:0]      s_data = '0;
  logic            s_last = 1'b0;
  logic            s_ready;
  logic [N*8-1:0]  tx_lane_data;
  logic [N-1:0]    tx_lane_act, tx_lane_keep;
  logic            tx_strobe, tx_end;
  logic            m_valid, m_last;
  logic [7:0]      m_data;

  always #5 clk = ~clk;

  lane_byte_striper #(.MAX_LANES(N), .PAD_BYTE(PAD)) u_lane_byte_striper (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_width(cfg_width),
    .link_width(link_width), .cfg_err(cfg_err),
    .s_valid(s_valid), .s_data(s_data), .s_last(s_last), .s_ready(s_ready),
    .tx_lane_data(tx_lane_data), .tx_lane_act(tx_lane_act), .tx_lane_keep(tx_lane_keep),
    .tx_strobe(tx_strobe), .tx_end(tx_end),
    .rx_strobe(tx_strobe), .rx_lane_data(tx_lane_data), .rx_lane_keep(tx_lane_keep),
    .rx_end(tx_end), .m_valid(m_valid), .m_data(m_data), .m_last(m_last)
  );

  logic [7:0] sent_d [0:8191];
  bit         sent_l [0:8191];
  int n_sent = 0, tx_ptr = 0, rx_ptr = 0, cur_w = 1;
  int vecs = 0, errs = 0;
  bit mon_en = 1'b0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (width %0d)", tag, act, exp, cur_w);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  endtask

  // Monitor: checks groups against the recorded stream, and the rebuilt stream.
  always @(negedge clk) begin
    if (mon_en && rst_n) begin
      if (tx_strobe) begin
        int n;
        bit ok4, ok5, ok6;
        int bad4, bad5, bad6;
        n = 0;
        for (int k = 0; k < cur_w; k++) begin
          if (tx_ptr + k >= n_sent) break;
          n++;
          if (sent_l[tx_ptr + k]) break;
        end
        ok4 = (n > 0); ok5 = 1'b1; ok6 = 1'b1; bad4 = -1; bad5 = -1; bad6 = -1;
        for (int i = 0; i < N; i++) begin
          if (i < n) begin
            if (tx_lane_data[i*8 +: 8] != sent_d[tx_ptr + i] || !tx_lane_act[i] || !tx_lane_keep[i]) begin
              ok4 = 1'b0; if (bad4 < 0) bad4 = i;
            end
          end else if (i < cur_w) begin
            if (tx_lane_data[i*8 +: 8] != PAD || !tx_lane_act[i] || tx_lane_keep[i]) begin
              ok5 = 1'b0; if (bad5 < 0) bad5 = i;
            end
          end else if (tx_lane_act[i] || tx_lane_keep[i]) begin
            ok6 = 1'b0; if (bad6 < 0) bad6 = i;
          end
        end
        // R4: filled lanes carry the stream bytes in lane order
        chk(ok4, "R4 group lanes", longint'(bad4), longint'(n));
        // R5: pad lanes and packet-end flag
        chk(ok5 && (n == 0 || tx_end == sent_l[tx_ptr + n - 1]), "R5 pad/end",
            longint'({tx_end, 8'(bad5)}), longint'(n));
        // R6: lanes above the width stay idle
        chk(ok6, "R6 upper lanes", longint'(bad6), -1);
        tx_ptr += n;
      end else begin
        // R6: no lane active between groups
        if (tx_lane_act != '0) chk(1'b0, "R6 idle act", longint'(tx_lane_act), 0);
      end
      if (m_valid) begin
        if (rx_ptr < n_sent) begin
          // R7 / R8: rebuilt byte and end marker match the input stream
          chk(m_data == sent_d[rx_ptr] && m_last == sent_l[rx_ptr], "R8 rebuilt byte",
              longint'({m_last, m_data}), longint'({sent_l[rx_ptr], sent_d[rx_ptr]}));
        end else begin
          chk(1'b0, "R7 extra byte", longint'(m_data), -1);
        end
        rx_ptr++;
      end
    end
  end

  task automatic configure(input int code, input int exp_w, input bit exp_err);
    @(negedge clk); #1;
    cfg_load = 1'b1; cfg_width = LW'(code);
    s_valid = 1'b1; s_data = 8'hEE; s_last = 1'b1;   // must be dropped
    @(negedge clk);
    // R3: no acceptance during the configure strobe
    chk(s_ready == 1'b0, "R3 ready low", longint'(s_ready), 0);
    #1;
    cfg_load = 1'b0; s_valid = 1'b0; s_last = 1'b0;
    @(negedge clk);
    // R1 / R2: resolved width and error flag
    chk(int'(link_width) == exp_w, "R1 width", longint'(link_width), longint'(exp_w));
    chk(cfg_err == exp_err, "R2 cfg_err", longint'(cfg_err), longint'(exp_err));
    cur_w = exp_w;
  endtask

  task automatic send_pkt(input int len, input int pid, input int seed);
    for (int b = 0; b < len; b++) begin
      if ((pid + b) % 5 == 3) begin
        @(negedge clk); #1; s_valid = 1'b0;
      end
      @(negedge clk); #1;
      s_valid = 1'b1;
      s_data  = 8'((pid * 29 + b * 7 + seed * 3 + 1) & 255);
      s_last  = (b == len - 1);
      sent_d[n_sent] = s_data;
      sent_l[n_sent] = s_last;
      n_sent++;
    end
    @(negedge clk); #1;
    s_valid = 1'b0; s_last = 1'b0;
  endtask

  task automatic drain_and_check();
    int guard;
    guard = 0;
    while ((rx_ptr < n_sent) && guard < 400) begin
      @(negedge clk); guard++;
    end
    repeat (4) @(negedge clk);
    // R8: every byte came out exactly once, no extra byte (R3 dropped byte included)
    chk(tx_ptr == n_sent, "R8 tx count", longint'(tx_ptr), longint'(n_sent));
    chk(rx_ptr == n_sent, "R8 rx count", longint'(rx_ptr), longint'(n_sent));
    n_sent = 0; tx_ptr = 0; rx_ptr = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    vecs++; errs++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end

  initial begin
    int legal [7];
    int bad [5];
    legal = '{1, 2, 4, 8, 12, 16, 32};
    bad   = '{0, 3, 5, 33, 63};
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state
    chk(int'(link_width) == 1, "R9 width", longint'(link_width), 1);
    chk(cfg_err == 1'b0, "R9 cfg_err", longint'(cfg_err), 0);
    chk(tx_strobe == 1'b0 && tx_lane_act == '0 && tx_lane_keep == '0, "R9 tx idle",
        longint'(tx_lane_act), 0);
    chk(m_valid == 1'b0, "R9 m_valid", longint'(m_valid), 0);
    mon_en = 1'b1;

    for (int c = 0; c < 7; c++) begin
      configure(legal[c], legal[c], 1'b0);
      for (int len = 1; len <= 2 * legal[c] + 3; len++) send_pkt(len, len + c, c);
      drain_and_check();
      if (c == 3) begin
        configure(bad[c - 3], 1, 1'b1);
        for (int len = 1; len <= 4; len++) send_pkt(len, len, 9);
        drain_and_check();
      end
    end
    for (int c = 0; c < 5; c++) begin
      configure(bad[c], 1, 1'b1);
      for (int len = 1; len <= 5; len++) send_pkt(len, len * 3, c + 11);
      drain_and_check();
    end
    // R2: legal load after an illegal one clears the flag
    configure(12, 12, 1'b0);
    for (int len = 11; len <= 26; len++) send_pkt(len, len, 17);
    drain_and_check();
    finish_run();
  end

endmodule